// File: doc/BRIEF.md
# Serial EEPROM Station Address Loader

This block fetches a 48-bit station address from a three-wire serial EEPROM of the 64-word or 256-word class, with no software involved. A one-cycle start strobe begins a run. The loader reads word 0 and compares it with a fixed signature. If the signature matches, it reads three more words and builds the station address from them. It publishes the address only when it is a usable unicast address.

Each word read is a complete serial transaction. The loader raises chip select and shifts out a read command, most significant bit first. The command length depends on an input that selects the EEPROM size. The loader then clocks in sixteen data bits and drops chip select. Every serial clock level lasts a whole number of half-periods, and the parameter `HALF_DIV` sets the length of one half-period. At the end of the run, `done` pulses once and the result outputs stay stable until the next run ends.

Top module: `eeprom_addr_loader`

## Requirements
- R1: After reset, `mw_cs`, `mw_clk`, `mw_mosi`, `busy`, `done`, `sig_ok` and `addr_valid` are 0 and `mac` is all zeros.
- R2: Every command starts with the opcode bits 1,1,0 and is followed by the word address, most significant bit first. When `wide_sel` is 0, the address is 6 bits and the command is 9 bits. When `wide_sel` is 1, the address is 8 bits and the command is 11 bits. `wide_sel` is captured in the cycle that start is accepted.
- R3: `mw_clk` is high only while `mw_cs` is high. `mw_mosi` does not change while `mw_clk` is high. `mw_cs` is high only while `busy` is high.
- R4: Each level of `mw_clk` lasts at least `HALF_DIV` clock cycles.
- R5: After the command, `mw_clk` returns low. Then 16 data bits are taken from `mw_miso`, most significant bit first, each one sampled at the end of a clock-high phase. Each word therefore produces exactly command length plus 16 rising edges on `mw_clk`.
- R6: If word 0 is not 0x8129, the run ends after that word. `done` pulses with `sig_ok` at 0 and `addr_valid` at 0, and `mac` keeps its previous value. `mac` changes only in a `done` cycle.
- R7: With a valid signature, words 7, 8 and 9 are read in that order. The address bytes, from first to last, are: word 7 low byte, word 7 high byte, word 8 low byte, word 8 high byte, word 9 low byte, word 9 high byte. They are placed in `mac[47:40]` down to `mac[7:0]`.
- R8: The assembled address is loaded into `mac`, with `addr_valid` set to 1, only when it is nonzero and `mac[40]` (the group bit of the first byte) is 0. Otherwise `addr_valid` is 0 and `mac` keeps its previous value.
- R9: `busy` is 1 from the cycle after start is accepted until `done`. `done` is high for exactly one cycle, and `busy` is 0 in that cycle. A start received while `busy` is 1 has no effect.
- R10: `sig_ok` is 1 after a run whose word 0 matched the signature, and it changes only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that begins a load |
| wide_sel | input | 1 | 0: 6-bit word address, 1: 8-bit word address |
| mw_miso | input | 1 | Serial data from the EEPROM |
| mw_cs | output | 1 | EEPROM chip select |
| mw_clk | output | 1 | Serial clock to the EEPROM |
| mw_mosi | output | 1 | Serial data to the EEPROM |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse at the end of a load |
| sig_ok | output | 1 | The last load found the signature |
| addr_valid | output | 1 | `mac` holds an address from a successful load |
| mac | output | 48 | Station address, first byte in [47:40] |

## Verification
`busy` rises one edge after start is sampled. The bench drives start at a falling edge and checks `busy` at the next falling edge. `done`, `sig_ok`, `addr_valid` and `mac` all update on the same edge. The bench polls at falling edges until it sees `done`, reads all four outputs in that same half-cycle, and confirms that `done` is low one cycle later. A bench model of the EEPROM answers each command. The model drives each data bit at the rising edge of `mw_clk`, at least `HALF_DIV` cycles before the loader samples it. The model also logs the opcode, the address and the number of clock edges in each transaction. The bench checks these logs after `done`, because chip select always falls before the run ends.

// File: rtl/eal_pkg.sv
package eal_pkg;

    localparam int WORD_W    = 16;
    localparam int OP_W      = 3;
    localparam int NARROW_AW = 6;
    localparam int WIDE_AW   = 8;
    localparam int CMD_W     = OP_W + WIDE_AW;
    localparam int MAC_W     = 48;

    localparam logic [OP_W-1:0]    RD_OP    = 3'b110;
    localparam logic [WORD_W-1:0]  SIG_WORD = 16'h8129;
    localparam logic [WIDE_AW-1:0] SIG_LOC  = 8'd0;
    localparam logic [WIDE_AW-1:0] MAC_LOC  = 8'd7;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_SEL,
        RD_SETUP,
        RD_CHI,
        RD_GAP,
        RD_DHI,
        RD_DLO
    } rd_state_e;

    typedef enum logic {
        SQ_IDLE,
        SQ_WAIT
    } sq_state_e;

    // Little-endian word: low byte is the earlier address byte.
    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8]};
    endfunction

    function automatic logic unicast_ok(input logic [MAC_W-1:0] a);
        return (a != '0) && !a[MAC_W-8];
    endfunction

endpackage

// File: rtl/eal_pacer.sv
module eal_pacer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(HALF_DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = !restart_i && (cnt_q == LAST);
        if (restart_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/eal_mw_reader.sv
module eal_mw_reader
    import eal_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               wide_i,
    input  logic [WIDE_AW-1:0] addr_i,
    input  logic               miso_i,
    output logic               cs_o,
    output logic               sk_o,
    output logic               mosi_o,
    output logic               rdy_o,
    output logic [WORD_W-1:0]  word_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(OP_W + NARROW_AW);
    localparam logic [CNT_W-1:0] LEN_DATA   = CNT_W'(WORD_W);

    typedef struct packed {
        rd_state_e          st;
        logic [CNT_W-1:0]   left;
        logic [CMD_W-1:0]   cmd;
        logic [WORD_W-1:0]  word;
        logic               cs;
        logic               sk;
        logic               mosi;
        logic               rdy;
    } rd_t;

    rd_t  d, q;
    logic tick;

    eal_pacer #(.HALF_DIV(HALF_DIV)) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (q.st == RD_IDLE),
        .tick_o    (tick)
    );

    always_comb begin
        d     = q;
        d.rdy = 1'b0;
        case (q.st)
            RD_IDLE: begin
                if (req_i) begin
                    d.st   = RD_SEL;
                    d.cs   = 1'b1;
                    d.sk   = 1'b0;
                    d.mosi = 1'b0;
                    if (wide_i) begin
                        d.left = LEN_WIDE;
                        d.cmd  = {RD_OP, addr_i};
                    end else begin
                        d.left = LEN_NARROW;
                        d.cmd  = {RD_OP, addr_i[NARROW_AW-1:0],
                                  {(WIDE_AW-NARROW_AW){1'b0}}};
                    end
                end
            end
            RD_SEL: begin
                if (tick) begin
                    d.st   = RD_SETUP;
                    d.mosi = q.cmd[CMD_W-1];
                end
            end
            RD_SETUP: begin
                if (tick) begin
                    d.sk = 1'b1;
                    d.st = RD_CHI;
                end
            end
            RD_CHI: begin
                if (tick) begin
                    d.sk   = 1'b0;
                    d.cmd  = {q.cmd[CMD_W-2:0], 1'b0};
                    d.left = q.left - 1'b1;
                    if (q.left == CNT_W'(1)) begin
                        d.st   = RD_GAP;
                        d.mosi = 1'b0;
                    end else begin
                        d.st   = RD_SETUP;
                        d.mosi = q.cmd[CMD_W-2];
                    end
                end
            end
            RD_GAP: begin
                if (tick) begin
                    d.sk   = 1'b1;
                    d.st   = RD_DHI;
                    d.left = LEN_DATA;
                end
            end
            RD_DHI: begin
                if (tick) begin
                    d.word = {q.word[WORD_W-2:0], miso_i};
                    d.sk   = 1'b0;
                    d.left = q.left - 1'b1;
                    d.st   = RD_DLO;
                end
            end
            RD_DLO: begin
                if (tick) begin
                    if (q.left == '0) begin
                        d.cs  = 1'b0;
                        d.rdy = 1'b1;
                        d.st  = RD_IDLE;
                    end else begin
                        d.sk = 1'b1;
                        d.st = RD_DHI;
                    end
                end
            end
            default: d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cs_o   = q.cs;
    assign sk_o   = q.sk;
    assign mosi_o = q.mosi;
    assign rdy_o  = q.rdy;
    assign word_o = q.word;

endmodule

// File: rtl/eal_seq.sv
module eal_seq
    import eal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               wide_sel_i,
    input  logic               rdy_i,
    input  logic [WORD_W-1:0]  word_i,
    output logic               req_o,
    output logic               wide_o,
    output logic [WIDE_AW-1:0] addr_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               sig_ok_o,
    output logic               addr_valid_o,
    output logic [MAC_W-1:0]   mac_o
);
    typedef struct packed {
        sq_state_e          st;
        logic [1:0]         idx;
        logic               wide;
        logic               req;
        logic [WIDE_AW-1:0] addr;
        logic [MAC_W-1:0]   acc;
        logic               busy;
        logic               done;
        logic               sig_ok;
        logic               av;
        logic [MAC_W-1:0]   mac;
    } sq_t;

    sq_t d, q;
    logic [MAC_W-1:0] acc_next;

    always_comb begin
        d        = q;
        d.req    = 1'b0;
        d.done   = 1'b0;
        acc_next = {q.acc[MAC_W-WORD_W-1:0], swap_bytes(word_i)};
        case (q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    d.st   = SQ_WAIT;
                    d.busy = 1'b1;
                    d.wide = wide_sel_i;
                    d.idx  = 2'd0;
                    d.req  = 1'b1;
                    d.addr = SIG_LOC;
                end
            end
            SQ_WAIT: begin
                if (rdy_i) begin
                    if (q.idx == 2'd0) begin
                        if (word_i == SIG_WORD) begin
                            d.idx  = 2'd1;
                            d.req  = 1'b1;
                            d.addr = MAC_LOC;
                        end else begin
                            d.st     = SQ_IDLE;
                            d.busy   = 1'b0;
                            d.done   = 1'b1;
                            d.sig_ok = 1'b0;
                            d.av     = 1'b0;
                        end
                    end else begin
                        d.acc = acc_next;
                        if (q.idx == 2'd3) begin
                            d.st     = SQ_IDLE;
                            d.busy   = 1'b0;
                            d.done   = 1'b1;
                            d.sig_ok = 1'b1;
                            if (unicast_ok(acc_next)) begin
                                d.mac = acc_next;
                                d.av  = 1'b1;
                            end else begin
                                d.av  = 1'b0;
                            end
                        end else begin
                            d.idx  = q.idx + 2'd1;
                            d.req  = 1'b1;
                            d.addr = MAC_LOC + WIDE_AW'(q.idx);
                        end
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_o        = q.req;
    assign wide_o       = q.wide;
    assign addr_o       = q.addr;
    assign busy_o       = q.busy;
    assign done_o       = q.done;
    assign sig_ok_o     = q.sig_ok;
    assign addr_valid_o = q.av;
    assign mac_o        = q.mac;

endmodule

// File: rtl/eeprom_addr_loader.sv
module eeprom_addr_loader
    import eal_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wide_sel,
    input  logic             mw_miso,
    output logic             mw_cs,
    output logic             mw_clk,
    output logic             mw_mosi,
    output logic             busy,
    output logic             done,
    output logic             sig_ok,
    output logic             addr_valid,
    output logic [MAC_W-1:0] mac
);
    logic               rd_req;
    logic               rd_wide;
    logic [WIDE_AW-1:0] rd_addr;
    logic               rd_rdy;
    logic [WORD_W-1:0]  rd_word;

    eal_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .wide_sel_i   (wide_sel),
        .rdy_i        (rd_rdy),
        .word_i       (rd_word),
        .req_o        (rd_req),
        .wide_o       (rd_wide),
        .addr_o       (rd_addr),
        .busy_o       (busy),
        .done_o       (done),
        .sig_ok_o     (sig_ok),
        .addr_valid_o (addr_valid),
        .mac_o        (mac)
    );

    eal_mw_reader #(.HALF_DIV(HALF_DIV)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (rd_req),
        .wide_i (rd_wide),
        .addr_i (rd_addr),
        .miso_i (mw_miso),
        .cs_o   (mw_cs),
        .sk_o   (mw_clk),
        .mosi_o (mw_mosi),
        .rdy_o  (rd_rdy),
        .word_o (rd_word)
    );

endmodule

// File: rtl/eal_chk.sv
module eal_chk #(
    parameter int HALF_DIV = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mw_cs,
    input logic        mw_clk,
    input logic        mw_mosi,
    input logic        busy,
    input logic        done,
    input logic        addr_valid,
    input logic [47:0] mac
);
    localparam int LW = $clog2(HALF_DIV + 2) + 1;
    localparam logic [LW-1:0] LMAX = '1;

    logic          clk_prev_q;
    logic          mosi_prev_q;
    logic [LW-1:0] run_q;
    logic [47:0]   mac_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev_q  <= 1'b0;
            mosi_prev_q <= 1'b0;
            run_q       <= '0;
            mac_prev_q  <= '0;
        end else begin
            clk_prev_q  <= mw_clk;
            mosi_prev_q <= mw_mosi;
            mac_prev_q  <= mac;
            if (mw_clk != clk_prev_q) begin
                run_q <= LW'(1);
            end else if (run_q != LMAX) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R3
    clk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mw_clk |-> mw_cs);

    // R3
    mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_clk && clk_prev_q) |-> (mw_mosi == mosi_prev_q));

    // R3
    cs_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mw_cs |-> busy);

    // R4
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_clk != clk_prev_q) |-> (run_q >= LW'(HALF_DIV)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    mac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac != mac_prev_q) |-> done);

    // R8
    valid_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> ((mac != '0) && !mac[40]));

endmodule

bind eeprom_addr_loader eal_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mw_cs      (mw_cs),
    .mw_clk     (mw_clk),
    .mw_mosi    (mw_mosi),
    .busy       (busy),
    .done       (done),
    .addr_valid (addr_valid),
    .mac        (mac)
);

// File: tb/sim_eeprom_addr_loader.sv
module sim_eeprom_addr_loader;
    localparam int TB_HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide_sel = 1'b0;
    logic        miso_r = 1'b0;
    logic        mw_cs, mw_clk, mw_mosi, busy, done, sig_ok, addr_valid;
    logic [47:0] mac;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    eeprom_addr_loader #(.HALF_DIV(TB_HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_sel(wide_sel),
        .mw_miso(miso_r), .mw_cs(mw_cs), .mw_clk(mw_clk), .mw_mosi(mw_mosi),
        .busy(busy), .done(done), .sig_ok(sig_ok), .addr_valid(addr_valid),
        .mac(mac)
    );

    // ---------------- EEPROM model ----------------
    logic [15:0] rom [0:255];
    logic        model_wide = 1'b0;
    int          rc = 0;
    logic [10:0] cmd_sh = '0;
    logic [15:0] cur = '0;
    int          nlog = 0;
    logic [7:0]  addr_log [0:7];
    int          bad_op = 0;
    int          bad_len = 0;

    always @(posedge mw_clk or negedge mw_cs) begin
        int clen;
        clen = model_wide ? 11 : 9;
        if (!mw_cs) begin
            if (rc != 0 && rc != clen + 16) bad_len++;
            rc = 0;
            cmd_sh = '0;
            miso_r = 1'b0;
        end else if (rc < clen) begin
            cmd_sh = {cmd_sh[9:0], mw_mosi};
            rc++;
            if (rc == clen) begin
                logic [2:0] op;
                logic [7:0] a;
                op = model_wide ? cmd_sh[10:8] : cmd_sh[8:6];
                a  = model_wide ? cmd_sh[7:0] : {2'b00, cmd_sh[5:0]};
                if (op != 3'b110) bad_op++;
                if (nlog < 8) addr_log[nlog] = a;
                nlog++;
                cur = rom[a];
            end
        end else begin
            if (rc - clen < 16) miso_r = cur[15 - (rc - clen)];
            rc++;
        end
    end

    // ---------------- serial pin monitor ----------------
    logic sk_prev = 1'b0, mosi_prev = 1'b0;
    int   runlen = 0, min_run = 1000000, bad_cs = 0, bad_di = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mw_clk && !mw_cs) bad_cs++;
            if (mw_clk && sk_prev && mw_mosi != mosi_prev) bad_di++;
            if (mw_clk != sk_prev) begin
                if (runlen < min_run) min_run = runlen;
                runlen = 1;
            end else begin
                runlen++;
            end
            sk_prev = mw_clk;
            mosi_prev = mw_mosi;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] build_mac(input logic [15:0] a,
                                              input logic [15:0] b,
                                              input logic [15:0] c);
        return {a[7:0], a[15:8], b[7:0], b[15:8], c[7:0], c[15:8]};
    endfunction

    function automatic bit good_addr(input logic [47:0] m);
        return (m != 48'd0) && (m[40] == 1'b0);
    endfunction

    logic [47:0] exp_mac = '0;
    bit          exp_av = 1'b0;

    task automatic run_one(input bit wide, input logic [15:0] sig,
                           input logic [15:0] w7, input logic [15:0] w8,
                           input logic [15:0] w9, input bit poke);
        int n;
        bit sgood;
        logic [47:0] cand;
        model_wide = wide;
        rom[0] = sig; rom[7] = w7; rom[8] = w8; rom[9] = w9;
        nlog = 0; bad_op = 0; bad_len = 0;
        @(negedge clk);
        wide_sel = wide;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wide_sel = ~wide;
        chk(busy == 1'b1, "R9 busy after start", 64'(busy), 64'd1);
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 6000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 6000, "R9 run timeout", 64'(n), 64'd6000);
        sgood = (sig == 16'h8129);
        cand = build_mac(w7, w8, w9);
        if (sgood && good_addr(cand)) begin
            exp_mac = cand;
            exp_av = 1'b1;
        end else begin
            exp_av = 1'b0;
        end
        chk(sig_ok == sgood, "R10 sig_ok", 64'(sig_ok), 64'(sgood));
        chk(addr_valid == exp_av, "R8 addr_valid", 64'(addr_valid), 64'(exp_av));
        chk(mac == exp_mac, "R7 mac", 64'(mac), 64'(exp_mac));
        chk(busy == 1'b0, "R9 busy at done", 64'(busy), 64'd0);
        chk(bad_op == 0, "R2 opcode", 64'(bad_op), 64'd0);
        chk(bad_len == 0, "R5 edges per word", 64'(bad_len), 64'd0);
        if (sgood) begin
            chk(nlog == 4, "R7 word count", 64'(nlog), 64'd4);
            chk(addr_log[0] == 8'd0 && addr_log[1] == 8'd7 &&
                addr_log[2] == 8'd8 && addr_log[3] == 8'd9, "R2 addresses",
                {32'd0, addr_log[0], addr_log[1], addr_log[2], addr_log[3]},
                64'h0000_0000_0007_0809);
        end else begin
            chk(nlog == 1, "R6 stops after signature", 64'(nlog), 64'd1);
            chk(addr_log[0] == 8'd0, "R2 signature address", 64'(addr_log[0]), 64'd0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", 64'(done), 64'd0);
        chk(busy == 1'b0, "R9 idle after done", 64'(busy), 64'd0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        int unused_seed;
        logic [15:0] s, a, b, c;
        unused_seed = $urandom(32'h00C0FFEE);
        for (int i = 0; i < 256; i++) rom[i] = 16'($urandom);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({mw_cs, mw_clk, mw_mosi, busy, done, sig_ok, addr_valid} == 7'd0,
            "R1 reset pins", 64'({mw_cs, mw_clk, mw_mosi, busy, done, sig_ok, addr_valid}), 64'd0);
        chk(mac == 48'd0, "R1 reset mac", 64'(mac), 64'd0);

        // directed corner cases
        run_one(1'b0, 16'h8129, 16'h3412, 16'h7856, 16'hBC9A, 1'b0); // R7 narrow
        run_one(1'b1, 16'h8129, 16'h1100, 16'h3322, 16'h5544, 1'b0); // R2 wide
        run_one(1'b1, 16'h8128, 16'h0000, 16'h0000, 16'h0002, 1'b0); // R6 bad sig, mac held
        run_one(1'b0, 16'h8129, 16'h0000, 16'h0000, 16'h0000, 1'b0); // R8 zero
        run_one(1'b1, 16'h8129, 16'hAA01, 16'h0000, 16'h0000, 1'b0); // R8 group bit
        run_one(1'b0, 16'h8129, 16'h0102, 16'h0304, 16'h0506, 1'b1); // R9 start ignored
        run_one(1'b0, 16'h2981, 16'h0a0b, 16'h0c0d, 16'h0e0f, 1'b1); // R6 byte-swapped sig

        // constrained random
        for (int i = 0; i < 24; i++) begin
            int kind;
            kind = int'($urandom % 8);
            s = (kind == 0) ? 16'($urandom) : 16'h8129;
            if (kind == 0 && s == 16'h8129) s = 16'h8120;
            a = 16'($urandom); b = 16'($urandom); c = 16'($urandom);
            if (kind == 1) a[0] = 1'b1;
            if (kind == 2) begin a = '0; b = '0; c = '0; end
            run_one(1'($urandom % 2), s, a, b, c, (kind == 3));
        end

        chk(min_run >= TB_HALF, "R4 half-period", 64'(min_run), 64'(TB_HALF));
        chk(bad_cs == 0, "R3 clock outside select", 64'(bad_cs), 64'd0);
        chk(bad_di == 0, "R3 data moved while clock high", 64'(bad_di), 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule